// File: doc/BRIEF.md
# I2C Target Front End with Busy Refusal

This block is the serial front end of a hashing or non-volatile-memory coprocessor. It runs on a system clock that is much faster than the bus. Both bus lines pass through a synchronizer and a digital glitch filter. The block finds the bus conditions (START, repeated START and STOP), shifts in a 7-bit target address and compares it with an address built from a fixed base value and three board straps. The straps land on bit positions 0, 2 and 4 of the address. After that, the block moves bytes between the bus and a simple per-byte handshake to the core.

The core steers acknowledgement in two ways. While the core is busy, for example during a hash round or a memory write cycle, the block leaves its own address unacknowledged. During a write transfer, the core can refuse any received byte. From then on the block leaves that byte and all later bytes of the transfer unacknowledged, until a STOP or a repeated START arrives. Until an address match has been acknowledged, the block ignores START and STOP conditions. The SDA output is an open-drain pull-down enable.

Top module: `i2c_busy_slave`

## Requirements
- R1: The 7-bit target address equals FIXED_ADDR (default 7'h40) with address bit 0 replaced by strap_i[0], bit 2 by strap_i[1] and bit 4 by strap_i[2]. The address byte carries the address in its upper seven bits, most significant bit first. On a match, the block pulls SDA low for the ninth (acknowledge) clock. On a mismatch, it leaves SDA released, raises no strobe, and a following STOP produces no stop_o.
- R2: Bit 0 of the address byte selects the direction: 0 means the controller writes and 1 means it reads. An acknowledged address raises xfer_start_o for one cycle, and xfer_rnw_o carries the direction bit in that same cycle.
- R3: If core_busy_i is high when the address byte completes, the address is not acknowledged and xfer_start_o stays low.
- R4: In a write transfer, each data byte is shifted in most significant bit first. After its eighth bit, rx_valid_o pulses with the byte on rx_byte_o. If rx_accept_i is high in that cycle, the byte is acknowledged.
- R5: If rx_accept_i is low when rx_valid_o pulses, that byte is not acknowledged. No later byte of the transfer is acknowledged or offered on rx_valid_o until a START or STOP.
- R6: In a read transfer, tx_req_o pulses after the address acknowledge and after each controller acknowledge, and tx_byte_i is taken in that cycle. Its bits appear on SDA most significant bit first, each one changed only after an SCL fall.
- R7: A controller non-acknowledge on a read byte releases SDA. No further tx_req_o is raised, and the block drives nothing for the rest of the transfer.
- R8: A STOP after an acknowledged address raises stop_o for one cycle, releases SDA and returns the block to idle. A partly received byte is discarded and never offered on rx_valid_o.
- R9: A repeated START after an acknowledged address begins a new address phase with no stop_o, and the new direction is honoured.
- R10: START and STOP conditions seen during the address phase, before the address is acknowledged, are ignored: bit shifting continues as if they had not happened.
- R11: Pulses on SCL or SDA that last fewer than FILT_LEN system-clock cycles (default 4) are filtered out and change neither bit sampling nor condition detection.
- R12: After reset, SDA is released and no strobe is active. Asserting reset in the middle of a transfer releases SDA immediately.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversampling the bus |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Address straps for address bits 0, 2 and 4 |
| core_busy_i | input | 1 | Core busy; the address is refused while high |
| xfer_start_o | output | 1 | One-cycle pulse when an address is acknowledged |
| xfer_rnw_o | output | 1 | Direction bit, valid with xfer_start_o (1 = read) |
| rx_valid_o | output | 1 | One-cycle pulse: a write byte is complete |
| rx_byte_o | output | 8 | Received byte, valid with rx_valid_o |
| rx_accept_i | input | 1 | Same-cycle accept (1) or refuse (0) of the offered byte |
| tx_req_o | output | 1 | One-cycle pulse: the next read byte is taken now |
| tx_byte_i | input | 8 | Read byte supplied by the core |
| stop_o | output | 1 | One-cycle pulse on a STOP that ends an addressed transfer |

## Verification
Matching, mismatching and strap-moved addresses show whether the interleaved strap positions are decoded, and a busy address shows the refusal path apart from a mismatch. Write runs in which the core accepts every byte are contrasted with runs in which it refuses the second byte, and reads ending in controller acknowledge are contrasted with reads ending in non-acknowledge. Together these separate the per-byte acknowledge rules in both directions. Further patterns test robustness and framing: a STOP injected mid-address, a STOP mid-data, a repeated START that flips direction, short spikes on both lines, and a reset during the acknowledge bit. They show whether conditions are gated by the acknowledged state, whether partial bytes are dropped, and whether the filter hides sub-threshold pulses.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

    localparam int BYTE_BITS = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_DATA,
        ST_WR_ACK,
        ST_RD_DATA,
        ST_RD_ACK,
        ST_HOLD
    } i2cs_state_e;

    typedef struct packed {
        logic start;   // SDA fell while SCL high
        logic stop;    // SDA rose while SCL high
        logic rise;    // SCL rising edge
        logic fall;    // SCL falling edge
        logic sda;     // filtered SDA level
    } bus_evt_t;

    // Straps land on interleaved address bits 0, 2 and 4.
    function automatic logic [6:0] target_addr(input logic [6:0] base,
                                               input logic [2:0] strap);
        logic [6:0] a;
        a    = base;
        a[0] = strap[0];
        a[2] = strap[1];
        a[4] = strap[2];
        return a;
    endfunction

endpackage

// File: rtl/i2cs_glitch_filter.sv
module i2cs_glitch_filter #(
    parameter int   FILT_LEN = 4,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic line_i,
    output logic line_o
);
    localparam int LEN = (FILT_LEN < 2) ? 2 : FILT_LEN;
    localparam int CW  = $clog2(LEN);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;
    logic          level_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q  <= {2{RST_VAL}};
            run_q   <= '0;
            level_q <= RST_VAL;
        end else begin
            sync_q <= {sync_q[0], line_i};
            if (sync_q[1] != level_q) begin
                if (run_q == CW'(LEN - 1)) begin
                    level_q <= sync_q[1];
                    run_q   <= '0;
                end else begin
                    run_q <= run_q + CW'(1);
                end
            end else begin
                run_q <= '0;
            end
        end
    end

    assign line_o = level_q;

    // A new filtered level must have been present at the synchronizer output for at least two cycles
    assert_filter_settled_R11: assert property (@(posedge clk) disable iff (rst)
        !$stable(level_q) |-> ($past(sync_q[1]) == level_q && $past(sync_q[1], 2) == level_q));

endmodule

// File: rtl/i2cs_cond_detect.sv
module i2cs_cond_detect
    import i2cs_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     scl_f,
    input  logic     sda_f,
    output bus_evt_t evt
);
    logic scl_prev_q;
    logic sda_prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_prev_q <= scl_f;
            sda_prev_q <= sda_f;
        end
    end

    always_comb begin
        evt.start = scl_f && scl_prev_q && sda_prev_q && !sda_f;
        evt.stop  = scl_f && scl_prev_q && !sda_prev_q && sda_f;
        evt.rise  = scl_f && !scl_prev_q;
        evt.fall  = !scl_f && scl_prev_q;
        evt.sda   = sda_f;
    end

    assert_cond_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({evt.start, evt.stop, evt.rise, evt.fall}));

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
#(
    parameter logic [6:0] FIXED_ADDR = 7'h40
) (
    input  logic                 clk,
    input  logic                 rst,
    input  bus_evt_t             evt,
    input  logic [2:0]           strap_i,
    input  logic                 core_busy_i,
    output logic                 sda_oe_o,
    output logic                 xfer_start_o,
    output logic                 xfer_rnw_o,
    output logic                 rx_valid_o,
    output logic [BYTE_BITS-1:0] rx_byte_o,
    input  logic                 rx_accept_i,
    output logic                 tx_req_o,
    input  logic [BYTE_BITS-1:0] tx_byte_i,
    output logic                 stop_o
);
    localparam int CW = $clog2(BYTE_BITS + 1);

    i2cs_state_e          state_q, state_d;
    logic [BYTE_BITS-1:0] shift_q, shift_d;
    logic [CW-1:0]        cnt_q, cnt_d;
    logic                 drive_q, drive_d;
    logic                 rnw_q, rnw_d;
    logic                 mack_q, mack_d;

    logic cond_ok;
    logic byte_done;
    logic addr_hit;

    // Conditions are honoured everywhere except while the address is still arriving.
    assign cond_ok   = (state_q != ST_ADDR);
    assign byte_done = (cnt_q == CW'(BYTE_BITS));
    assign addr_hit  = (shift_q[BYTE_BITS-1:1] == target_addr(FIXED_ADDR, strap_i));

    always_comb begin
        state_d      = state_q;
        shift_d      = shift_q;
        cnt_d        = cnt_q;
        drive_d      = drive_q;
        rnw_d        = rnw_q;
        mack_d       = mack_q;
        xfer_start_o = 1'b0;
        rx_valid_o   = 1'b0;
        tx_req_o     = 1'b0;
        stop_o       = 1'b0;

        if (evt.stop && cond_ok) begin
            stop_o  = (state_q != ST_IDLE);
            state_d = ST_IDLE;
            drive_d = 1'b0;
            cnt_d   = '0;
        end else if (evt.start && cond_ok) begin
            state_d = ST_ADDR;
            drive_d = 1'b0;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_HOLD: begin
                end
                ST_ADDR: begin
                    if (evt.rise && !byte_done) begin
                        shift_d = {shift_q[BYTE_BITS-2:0], evt.sda};
                        cnt_d   = cnt_q + CW'(1);
                    end else if (evt.fall && byte_done) begin
                        cnt_d = '0;
                        if (addr_hit && !core_busy_i) begin
                            state_d      = ST_ADDR_ACK;
                            drive_d      = 1'b1;
                            rnw_d        = shift_q[0];
                            xfer_start_o = 1'b1;
                        end else begin
                            state_d = ST_IDLE;
                            drive_d = 1'b0;
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (evt.fall) begin
                        cnt_d = '0;
                        if (rnw_q) begin
                            tx_req_o = 1'b1;
                            shift_d  = tx_byte_i;
                            drive_d  = !tx_byte_i[BYTE_BITS-1];
                            state_d  = ST_RD_DATA;
                        end else begin
                            drive_d = 1'b0;
                            state_d = ST_WR_DATA;
                        end
                    end
                end
                ST_WR_DATA: begin
                    if (evt.rise && !byte_done) begin
                        shift_d = {shift_q[BYTE_BITS-2:0], evt.sda};
                        cnt_d   = cnt_q + CW'(1);
                    end else if (evt.fall && byte_done) begin
                        rx_valid_o = 1'b1;
                        cnt_d      = '0;
                        if (rx_accept_i) begin
                            drive_d = 1'b1;
                            state_d = ST_WR_ACK;
                        end else begin
                            drive_d = 1'b0;
                            state_d = ST_HOLD;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (evt.fall) begin
                        drive_d = 1'b0;
                        state_d = ST_WR_DATA;
                    end
                end
                ST_RD_DATA: begin
                    if (evt.fall) begin
                        if (cnt_q == CW'(BYTE_BITS - 1)) begin
                            drive_d = 1'b0;
                            state_d = ST_RD_ACK;
                        end else begin
                            shift_d = {shift_q[BYTE_BITS-2:0], 1'b0};
                            drive_d = !shift_q[BYTE_BITS-2];
                            cnt_d   = cnt_q + CW'(1);
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (evt.rise) begin
                        mack_d = !evt.sda;
                    end else if (evt.fall) begin
                        cnt_d = '0;
                        if (mack_q) begin
                            tx_req_o = 1'b1;
                            shift_d  = tx_byte_i;
                            drive_d  = !tx_byte_i[BYTE_BITS-1];
                            state_d  = ST_RD_DATA;
                        end else begin
                            state_d = ST_HOLD;
                        end
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            shift_q <= '0;
            cnt_q   <= '0;
            drive_q <= 1'b0;
            rnw_q   <= 1'b0;
            mack_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            shift_q <= shift_d;
            cnt_q   <= cnt_d;
            drive_q <= drive_d;
            rnw_q   <= rnw_d;
            mack_q  <= mack_d;
        end
    end

    assign sda_oe_o   = drive_q;
    assign rx_byte_o  = shift_q;
    assign xfer_rnw_o = shift_q[0];

    assert_busy_refuse_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR && evt.fall && byte_done && core_busy_i) |=> !sda_oe_o && !xfer_start_o);

    assert_one_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({xfer_start_o, rx_valid_o, tx_req_o, stop_o}));

    assert_refused_nack_R5: assert property (@(posedge clk) disable iff (rst)
        (rx_valid_o && !rx_accept_i) |=> !sda_oe_o);

    assert_hold_silent_R5: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_HOLD) |-> (!sda_oe_o && !rx_valid_o && !tx_req_o));

    assert_read_msb_R6: assert property (@(posedge clk) disable iff (rst)
        tx_req_o |=> (sda_oe_o == !$past(tx_byte_i[BYTE_BITS-1])));

    assert_sda_moves_scl_low_R6: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_oe_o) |-> $past(evt.fall || ((evt.start || evt.stop) && cond_ok)));

    assert_stop_release_R8: assert property (@(posedge clk) disable iff (rst)
        stop_o |=> (!sda_oe_o && state_q == ST_IDLE));

    assert_addr_phase_blind_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_ADDR && !evt.fall) |=> (state_q == ST_ADDR));

endmodule

// File: rtl/i2c_busy_slave.sv
module i2c_busy_slave
    import i2cs_pkg::*;
#(
    parameter logic [6:0] FIXED_ADDR = 7'h40,
    parameter int         FILT_LEN   = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       core_busy_i,
    output logic       xfer_start_o,
    output logic       xfer_rnw_o,
    output logic       rx_valid_o,
    output logic [7:0] rx_byte_o,
    input  logic       rx_accept_i,
    output logic       tx_req_o,
    input  logic [7:0] tx_byte_i,
    output logic       stop_o
);
    logic     scl_f;
    logic     sda_f;
    bus_evt_t evt;

    i2cs_glitch_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_scl_filt (
        .clk    (clk),
        .rst    (rst),
        .line_i (scl_i),
        .line_o (scl_f)
    );

    i2cs_glitch_filter #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) u_sda_filt (
        .clk    (clk),
        .rst    (rst),
        .line_i (sda_i),
        .line_o (sda_f)
    );

    i2cs_cond_detect u_cond (
        .clk   (clk),
        .rst   (rst),
        .scl_f (scl_f),
        .sda_f (sda_f),
        .evt   (evt)
    );

    i2cs_engine #(.FIXED_ADDR(FIXED_ADDR)) u_engine (
        .clk          (clk),
        .rst          (rst),
        .evt          (evt),
        .strap_i      (strap_i),
        .core_busy_i  (core_busy_i),
        .sda_oe_o     (sda_oe_o),
        .xfer_start_o (xfer_start_o),
        .xfer_rnw_o   (xfer_rnw_o),
        .rx_valid_o   (rx_valid_o),
        .rx_byte_o    (rx_byte_o),
        .rx_accept_i  (rx_accept_i),
        .tx_req_o     (tx_req_o),
        .tx_byte_i    (tx_byte_i),
        .stop_o       (stop_o)
    );

    assert_reset_quiet_R12: assert property (@(posedge clk)
        rst |=> (!sda_oe_o && !xfer_start_o && !rx_valid_o && !tx_req_o && !stop_o));

endmodule

// File: tb/i2c_busy_slave_tb.sv
module i2c_busy_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 16;   // quarter SCL period in system clocks

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       scl_m = 1'b1;
    logic       sda_m_low = 1'b0;
    logic       sda_bus;
    logic       sda_oe_o;
    logic [2:0] strap_i = 3'b101;
    logic       core_busy_i = 1'b0;
    logic       xfer_start_o, xfer_rnw_o, rx_valid_o, tx_req_o, stop_o;
    logic [7:0] rx_byte_o, tx_byte_i;
    logic       rx_accept_i;

    int n_start = 0, n_stop = 0, n_rx = 0, n_tx = 0;
    logic last_rnw = 1'b0;
    logic [7:0] rx_mem [8];
    logic [7:0] tx_mem [4];
    int acc_limit = 1000;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign sda_bus     = !(sda_m_low || sda_oe_o);
    assign rx_accept_i = (n_rx < acc_limit);
    assign tx_byte_i   = tx_mem[n_tx[1:0]];

    i2c_busy_slave u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe_o),
        .strap_i(strap_i), .core_busy_i(core_busy_i),
        .xfer_start_o(xfer_start_o), .xfer_rnw_o(xfer_rnw_o),
        .rx_valid_o(rx_valid_o), .rx_byte_o(rx_byte_o), .rx_accept_i(rx_accept_i),
        .tx_req_o(tx_req_o), .tx_byte_i(tx_byte_i), .stop_o(stop_o)
    );

    // Core-side monitor: logs strobes seen at the interface.
    always @(posedge clk) begin
        if (xfer_start_o) begin n_start <= n_start + 1; last_rnw <= xfer_rnw_o; end
        if (stop_o)       n_stop <= n_stop + 1;
        if (rx_valid_o) begin rx_mem[n_rx[2:0]] <= rx_byte_o; n_rx <= n_rx + 1; end
        if (tx_req_o)     n_tx <= n_tx + 1;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic waitc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bus controller model ------------------------------------------------
    task automatic bus_start();   // also used for repeated START from SCL low
        sda_m_low = 1'b0; waitc(Q);
        scl_m = 1'b1;     waitc(Q);
        sda_m_low = 1'b1; waitc(Q);
        scl_m = 1'b0;     waitc(Q);
    endtask

    task automatic bus_stop();
        sda_m_low = 1'b1; waitc(Q);
        scl_m = 1'b1;     waitc(Q);
        sda_m_low = 1'b0; waitc(Q);
    endtask

    task automatic send_bit(input logic b);
        sda_m_low = !b; waitc(Q);
        scl_m = 1'b1;   waitc(2*Q);
        scl_m = 1'b0;   waitc(Q);
    endtask

    task automatic send_bit_g(input logic b);   // spikes on both lines while SCL high
        sda_m_low = !b; waitc(Q);
        scl_m = 1'b1;   waitc(6);
        scl_m = 1'b0;   waitc(2);
        scl_m = 1'b1;   waitc(6);
        sda_m_low = b;  waitc(2);
        sda_m_low = !b; waitc(2*Q-16);
        scl_m = 1'b0;   waitc(Q);
    endtask

    task automatic recv_bit(output logic b);
        sda_m_low = 1'b0; waitc(Q);
        scl_m = 1'b1;     waitc(Q);
        b = sda_bus;      waitc(Q);
        scl_m = 1'b0;     waitc(Q);
    endtask

    task automatic write_byte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic read_byte(output logic [7:0] d, input logic mack);
        logic b;
        for (int i = 7; i >= 0; i--) begin recv_bit(b); d[i] = b; end
        send_bit(!mack);
    endtask

    // Scenarios -------------------------------------------------------------
    task automatic t_reset();
        chk("R12 sda released after reset", sda_oe_o, 0);
        chk("R12 no strobes after reset", {xfer_start_o, rx_valid_o, tx_req_o, stop_o}, 0);
    endtask

    task automatic t_write();
        logic ack; int s0 = n_start, p0 = n_stop, r0 = n_rx;
        bus_start();
        write_byte(8'hA2, ack);
        chk("R1 address 0x51 acknowledged", ack, 1);
        chk("R2 xfer_start pulsed", n_start, s0 + 1);
        chk("R2 direction write", last_rnw, 0);
        write_byte(8'h3C, ack); chk("R4 byte0 acknowledged", ack, 1);
        write_byte(8'hC5, ack); chk("R4 byte1 acknowledged", ack, 1);
        chk("R4 byte count", n_rx, r0 + 2);
        chk("R4 byte0 value", rx_mem[r0[2:0]], 8'h3C);
        chk("R4 byte1 value", rx_mem[(r0 + 1) % 8], 8'hC5);
        bus_stop();
        chk("R8 stop_o pulsed", n_stop, p0 + 1);
        chk("R8 sda released after stop", sda_oe_o, 0);
    endtask

    task automatic t_mismatch();
        logic ack; int s0 = n_start, p0 = n_stop;
        bus_start();
        write_byte(8'hAA, ack);
        chk("R1 wrong address not acknowledged", ack, 0);
        bus_stop();
        chk("R1 no xfer_start on mismatch", n_start, s0);
        chk("R1 no stop_o after mismatch", n_stop, p0);
        strap_i = 3'b010;
        bus_start();
        write_byte(8'hA2, ack);
        chk("R1 old address refused after strap change", ack, 0);
        bus_start();
        write_byte(8'h88, ack);
        chk("R1 strap 010 address 0x44 acknowledged", ack, 1);
        bus_stop();
        strap_i = 3'b101;
    endtask

    task automatic t_busy();
        logic ack; int s0 = n_start;
        core_busy_i = 1'b1;
        bus_start();
        write_byte(8'hA2, ack);
        chk("R3 busy address not acknowledged", ack, 0);
        chk("R3 no xfer_start while busy", n_start, s0);
        bus_stop();
        core_busy_i = 1'b0;
        bus_start();
        write_byte(8'hA2, ack);
        chk("R3 acknowledged once idle", ack, 1);
        bus_stop();
    endtask

    task automatic t_refuse();
        logic ack; int r0 = n_rx;
        acc_limit = n_rx + 1;
        bus_start();
        write_byte(8'hA2, ack);
        write_byte(8'h11, ack); chk("R4 accepted byte acknowledged", ack, 1);
        write_byte(8'h22, ack); chk("R5 refused byte not acknowledged", ack, 0);
        write_byte(8'h33, ack); chk("R5 later byte not acknowledged", ack, 0);
        chk("R5 no byte offered after refusal", n_rx, r0 + 2);
        bus_stop();
        acc_limit = 1000;
    endtask

    task automatic t_read();
        logic ack; logic [7:0] d; int t0 = n_tx;
        tx_mem[n_tx[1:0]]       = 8'hA5;
        tx_mem[(n_tx + 1) % 4]  = 8'h3C;
        bus_start();
        write_byte(8'hA3, ack);
        chk("R2 read address acknowledged", ack, 1);
        chk("R2 direction read", last_rnw, 1);
        read_byte(d, 1'b1); chk("R6 read byte0", d, 8'hA5);
        read_byte(d, 1'b0); chk("R6 read byte1", d, 8'h3C);
        chk("R6 tx_req count", n_tx, t0 + 2);
        chk("R7 sda released after controller nack", sda_oe_o, 0);
        read_byte(d, 1'b0);
        chk("R7 bus idle-high after nack", d, 8'hFF);
        chk("R7 no further tx_req", n_tx, t0 + 2);
        bus_stop();
    endtask

    task automatic t_rstart();
        logic ack; logic [7:0] d; int s0 = n_start, p0 = n_stop;
        tx_mem[n_tx[1:0]] = 8'h69;
        bus_start();
        write_byte(8'hA2, ack);
        write_byte(8'h5A, ack);
        bus_start();
        write_byte(8'hA3, ack);
        chk("R9 address after repeated start acknowledged", ack, 1);
        chk("R9 no stop_o on repeated start", n_stop, p0);
        chk("R9 new direction read", last_rnw, 1);
        read_byte(d, 1'b0);
        chk("R9 read after repeated start", d, 8'h69);
        bus_stop();
        chk("R9 two transfers started", n_start, s0 + 2);
    endtask

    task automatic t_ignore();
        logic b; int s0 = n_start, p0 = n_stop;
        bus_start();
        send_bit(1); send_bit(0); send_bit(1); send_bit(0);
        bus_stop();                      // its SCL rise shifts a 0 as bit 5
        scl_m = 1'b0; waitc(Q);
        send_bit(0); send_bit(1); send_bit(0);
        recv_bit(b);
        chk("R10 stop in address phase ignored, address acked", !b, 1);
        chk("R10 no stop_o from ignored stop", n_stop, p0);
        chk("R10 transfer started", n_start, s0 + 1);
        bus_stop();
        chk("R10 stop after ack honoured", n_stop, p0 + 1);
    endtask

    task automatic t_partial();
        logic ack; int r0 = n_rx, p0 = n_stop;
        bus_start();
        write_byte(8'hA2, ack);
        send_bit(1); send_bit(1); send_bit(0); send_bit(1);
        bus_stop();
        chk("R8 partial byte discarded", n_rx, r0);
        chk("R8 stop_o during data", n_stop, p0 + 1);
        bus_start();
        write_byte(8'hA2, ack);
        write_byte(8'h77, ack);
        chk("R8 next byte clean after partial", rx_mem[r0[2:0]], 8'h77);
        bus_stop();
    endtask

    task automatic t_glitch();
        logic ack; logic b; int r0 = n_rx;
        sda_m_low = 1'b1; waitc(2); sda_m_low = 1'b0; waitc(Q);   // spike on idle bus
        scl_m = 1'b0; waitc(Q);
        for (int i = 7; i >= 0; i--) send_bit(8'hA2 >> i);
        recv_bit(b);
        chk("R11 idle spike not taken as start", !b, 0);
        bus_stop();
        bus_start();
        write_byte(8'hA2, ack);
        for (int i = 7; i >= 0; i--) send_bit_g(8'h96 >> i);
        recv_bit(b);
        chk("R11 byte with spikes acknowledged", !b, 1);
        chk("R11 byte with spikes value", rx_mem[r0[2:0]], 8'h96);
        bus_stop();
    endtask

    task automatic t_reset_mid();
        logic b;
        bus_start();
        for (int i = 7; i >= 0; i--) send_bit(8'hA2 >> i);
        sda_m_low = 1'b0; waitc(Q);
        chk("R1 ack driven during ninth bit", sda_oe_o, 1);
        rst = 1'b1; waitc(2); rst = 1'b0;
        chk("R12 reset releases sda mid transfer", sda_oe_o, 0);
        recv_bit(b);
        bus_stop();
    endtask

    initial begin
        for (int i = 0; i < 4; i++) tx_mem[i] = 8'h00;
        for (int i = 0; i < 8; i++) rx_mem[i] = 8'h00;
        waitc(5); rst = 1'b0; waitc(2*Q);
        t_reset();
        t_write();
        t_mismatch();
        t_busy();
        t_refuse();
        t_read();
        t_rstart();
        t_ignore();
        t_partial();
        t_glitch();
        t_reset_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule